// File: doc/BRIEF.md
# Parallel Neuron Layer Engine

This block evaluates one fully connected neural-network layer. A single start pulse launches up to `NEURONS` neurons at once. Every neuron multiplies each of its `INPUTS` signed weights by the matching shared signed input. Each product is cut down by an arithmetic right shift of `SHIFT_PROD` bits, and the shifted products are summed in a pipelined adder tree that belongs to that neuron. The neuron's threshold is added to the sum, which is then cut down again by `SHIFT_SUM` bits. The result passes through a rectifier: negative values become zero, and large positive values saturate at the largest signed `OUT_W`-bit value.

All lanes finish in the same cycle. The packed result bus is updated together with a one-cycle valid strobe, and it keeps its value until the next computation completes. Because the outputs have the same width as the inputs, a surrounding controller can feed them straight back as the inputs of the next layer. The operands are taken only in the cycle that the start pulse is accepted. The loader is therefore free to change them while the layer is being computed.

Top module: `nle_layer_engine`

## Requirements
- R1: While `rst_n` is low, and after reset until the first completion, `result_valid` is 0 and `result` is all zeros.
- R2: Lane n of `result` (bits n*OUT_W upward) equals sum over k of ((w[n][k] * x[k]) >>> SHIFT_PROD), plus thr[n], all shifted >>> SHIFT_SUM. Here w[n][k] sits at bits (n*INPUTS+k)*W_W of `weights`, x[k] at bits k*X_W of `inputs`, and thr[n] at bits n*W_W of `thresholds`. All values are signed two's complement and all shifts are arithmetic (they round toward minus infinity).
- R3: A lane whose R2 value is negative reads 0.
- R4: A lane whose R2 value exceeds 2^(OUT_W-1)-1 reads 2^(OUT_W-1)-1 (32767 for 16 bits).
- R5: A start accepted at clock edge E raises `result_valid` after edge E+DEPTH+1, where DEPTH = ceil(log2(INPUTS)). Before that it stays 0. For INPUTS=5 the strobe follows the 4th edge after E.
- R6: `result_valid` is high for exactly one cycle per accepted start.
- R7: A start raised while a computation is in progress, including the cycle in which `result_valid` is high, is ignored. It produces no further strobe and does not change `result`.
- R8: `result` changes only at the edge that raises `result_valid`.
- R9: The operands are sampled only at the edge that accepts the start. Changes to them afterwards do not affect that result.
- R10: A start raised in the cycle right after the strobe is accepted. Back-to-back layers therefore run with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only when idle |
| weights | input | NEURONS*INPUTS*W_W | Packed signed weights, neuron-major |
| thresholds | input | NEURONS*W_W | Packed signed per-neuron thresholds |
| inputs | input | INPUTS*X_W | Packed signed shared inputs |
| result | output | NEURONS*OUT_W | Packed rectified outputs, held between completions |
| result_valid | output | 1 | One-cycle strobe when `result` has just updated |

## Verification
Two events can fall in the same cycle: the emission of a finished layer, and the arrival of a new start request. A start in the strobe cycle must be ignored, while a start in the very next cycle must launch. The bench raises start during the emit cycle and a few cycles into the computation, and checks that no second strobe appears and that the result bus stays frozen. It also chains every ordinary run so that each launch is requested in the first idle cycle after the previous strobe. That run must then strobe on schedule with its own arithmetically predicted values, including operands scrambled right after launch and inputs that drive lanes into both the rectifier and saturation.

// File: rtl/nle_pkg.sv
package nle_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_EMIT  = 2'd2
   } nle_state_e;

   function automatic int unsigned tree_depth(input int unsigned n);
      return (n > 1) ? $clog2(n) : 0;
   endfunction
endpackage

// File: rtl/nle_ctrl.sv
module nle_ctrl
   import nle_pkg::*;
#(
   parameter int unsigned SUM_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic capture,
   output logic load,
   output logic emit
);
   localparam int unsigned CW = (SUM_CYCLES > 1) ? $clog2(SUM_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(SUM_CYCLES - 1);

   nle_state_e state_q;
   logic [CW-1:0] cnt_q;

   assign capture = (state_q == ST_IDLE) && start;
   assign load    = (state_q == ST_ACCUM) && (cnt_q == LAST);
   assign emit    = (state_q == ST_EMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (start) state_q <= ST_ACCUM;
            end
            ST_ACCUM: begin
               if (cnt_q == LAST) state_q <= ST_EMIT;
               else               cnt_q   <= cnt_q + 1'b1;
            end
            ST_EMIT: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nle_adder_tree.sv
module nle_adder_tree
   import nle_pkg::*;
#(
   parameter int unsigned N = 5,
   parameter int unsigned W = 40
) (
   input  logic                  clk,
   input  logic [N*W-1:0]        leaves,
   output logic signed [W-1:0]   sum
);
   localparam int unsigned D = tree_depth(N);
   localparam int unsigned L = 1 << D;

   for (genvar lv = 0; lv <= D; lv++) begin : g_lv
      logic signed [W-1:0] s [0:(L>>lv)-1];
      if (lv == 0) begin : g_leaf
         for (genvar i = 0; i < L; i++) begin : g_i
            if (i < N) begin : g_real
               assign s[i] = $signed(leaves[i*W +: W]);
            end else begin : g_pad
               assign s[i] = '0;
            end
         end
      end else begin : g_add
         always_ff @(posedge clk) begin
            for (int j = 0; j < (L >> lv); j++) begin
               s[j] <= g_lv[lv-1].s[2*j] + g_lv[lv-1].s[2*j+1];
            end
         end
      end
   end

   assign sum = g_lv[D].s[0];
endmodule

// File: rtl/nle_neuron.sv
module nle_neuron
   import nle_pkg::*;
#(
   parameter int unsigned INPUTS     = 5,
   parameter int unsigned W_W        = 24,
   parameter int unsigned X_W        = 16,
   parameter int unsigned OUT_W      = 16,
   parameter int unsigned SHIFT_PROD = 8,
   parameter int unsigned SHIFT_SUM  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   capture,
   input  logic                   load,
   input  logic [INPUTS*W_W-1:0]  w_vec,
   input  logic [INPUTS*X_W-1:0]  x_vec,
   input  logic [W_W-1:0]         thr,
   output logic [OUT_W-1:0]       y
);
   localparam int unsigned D  = tree_depth(INPUTS);
   localparam int unsigned MW = W_W + X_W;
   localparam int unsigned PW = MW - SHIFT_PROD;
   localparam int unsigned SW = ((PW > W_W) ? PW : W_W) + D + 1;

   logic [INPUTS*SW-1:0] leaf_q;
   logic signed [SW-1:0] tree_sum;

   for (genvar k = 0; k < INPUTS; k++) begin : g_mul
      logic signed [W_W-1:0] ws;
      logic signed [X_W-1:0] xs;
      logic signed [MW-1:0]  prod;
      logic signed [PW-1:0]  pshift;
      assign ws     = $signed(w_vec[k*W_W +: W_W]);
      assign xs     = $signed(x_vec[k*X_W +: X_W]);
      assign prod   = MW'(ws) * MW'(xs);
      assign pshift = PW'(prod >>> SHIFT_PROD);
      always_ff @(posedge clk) begin
         if (capture) leaf_q[k*SW +: SW] <= SW'(pshift);
      end
   end

   logic signed [W_W-1:0] thr_q;
   always_ff @(posedge clk) begin
      if (capture) thr_q <= $signed(thr);
   end

   nle_adder_tree #(.N(INPUTS), .W(SW)) u_tree (
      .clk    (clk),
      .leaves (leaf_q),
      .sum    (tree_sum)
   );

   logic signed [SW-1:0] total, scaled;
   logic [OUT_W-1:0]     y_d;

   always_comb begin
      total  = tree_sum + SW'(thr_q);
      scaled = total >>> SHIFT_SUM;
      if (scaled[SW-1])                  y_d = '0;
      else if (|scaled[SW-2:OUT_W-1])    y_d = {1'b0, {(OUT_W-1){1'b1}}};
      else                               y_d = OUT_W'(scaled);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    y <= '0;
      else if (load) y <= y_d;
   end
endmodule

// File: rtl/nle_layer_engine.sv
module nle_layer_engine
   import nle_pkg::*;
#(
   parameter int unsigned NEURONS    = 24,
   parameter int unsigned INPUTS     = 24,
   parameter int unsigned W_W        = 24,
   parameter int unsigned X_W        = 16,
   parameter int unsigned OUT_W      = 16,
   parameter int unsigned SHIFT_PROD = 8,
   parameter int unsigned SHIFT_SUM  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NEURONS*INPUTS*W_W-1:0] weights,
   input  logic [NEURONS*W_W-1:0]        thresholds,
   input  logic [INPUTS*X_W-1:0]         inputs,
   output logic [NEURONS*OUT_W-1:0]      result,
   output logic                          result_valid
);
   localparam int unsigned D  = tree_depth(INPUTS);
   localparam int unsigned MW = W_W + X_W;
   localparam int unsigned PW = MW - SHIFT_PROD;
   localparam int unsigned SW = ((PW > W_W) ? PW : W_W) + D + 1;

   if (NEURONS < 1 || INPUTS < 1) begin : g_bad_count
      $error("nle_layer_engine: NEURONS and INPUTS must be at least 1");
   end
   if (SHIFT_PROD >= MW) begin : g_bad_s1
      $error("nle_layer_engine: SHIFT_PROD must be below W_W+X_W");
   end
   if (SHIFT_SUM >= SW || SW < OUT_W + 1 || OUT_W < 2) begin : g_bad_s2
      $error("nle_layer_engine: SHIFT_SUM or OUT_W out of range");
   end

   logic capture, load;

   nle_ctrl #(.SUM_CYCLES(D + 1)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .capture (capture),
      .load    (load),
      .emit    (result_valid)
   );

   for (genvar n = 0; n < NEURONS; n++) begin : g_lane
      nle_neuron #(
         .INPUTS     (INPUTS),
         .W_W        (W_W),
         .X_W        (X_W),
         .OUT_W      (OUT_W),
         .SHIFT_PROD (SHIFT_PROD),
         .SHIFT_SUM  (SHIFT_SUM)
      ) u_neuron (
         .clk     (clk),
         .rst_n   (rst_n),
         .capture (capture),
         .load    (load),
         .w_vec   (weights[n*INPUTS*W_W +: INPUTS*W_W]),
         .x_vec   (inputs),
         .thr     (thresholds[n*W_W +: W_W]),
         .y       (result[n*OUT_W +: OUT_W])
      );
   end
endmodule

// File: rtl/nle_layer_engine_chk.sv
module nle_layer_engine_chk
   import nle_pkg::*;
#(
   parameter int unsigned NEURONS = 24,
   parameter int unsigned INPUTS  = 24,
   parameter int unsigned OUT_W   = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic [NEURONS*OUT_W-1:0] result,
   input logic                     result_valid
);
   localparam int unsigned LAT = tree_depth(INPUTS) + 2;

   logic [7:0] age_q;
   logic [NEURONS-1:0] signs;

   for (genvar n = 0; n < NEURONS; n++) begin : g_sign
      assign signs[n] = result[n*OUT_W + OUT_W - 1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       age_q <= '0;
      else if (age_q == 8'(LAT))        age_q <= '0;
      else if (age_q != '0)             age_q <= age_q + 8'd1;
      else if (start)                   age_q <= 8'd1;
   end

   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 8'(LAT)) |-> result_valid);

   p_no_extra_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (age_q == 8'(LAT)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable(result));

   p_rectified_r3: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (signs == '0));

   always_comb begin
      if (!rst_n) begin
         a_reset_r1: assert (result_valid == 1'b0);
      end
   end
endmodule

bind nle_layer_engine nle_layer_engine_chk #(
   .NEURONS (NEURONS),
   .INPUTS  (INPUTS),
   .OUT_W   (OUT_W)
) u_chk (.*);

// File: tb/nle_layer_engine_tb.sv
module nle_layer_engine_tb;
   localparam int P = 4, I = 5, WW = 24, IW = 16, OW = 16, S1 = 6, S2 = 4;
   localparam int D = 3;
   localparam longint MAXV = 32767;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [P*I*WW-1:0] wts = '0;
   logic [P*WW-1:0]   thr = '0;
   logic [I*IW-1:0]   ins = '0;
   logic [P*OW-1:0]   result;
   logic              result_valid;

   int checks = 0, errors = 0;
   int unsigned rng = 32'h1234_5678;
   longint expv [P];
   logic [P*OW-1:0] held;

   always #5 clk = ~clk;

   nle_layer_engine #(
      .NEURONS(P), .INPUTS(I), .W_W(WW), .X_W(IW), .OUT_W(OW),
      .SHIFT_PROD(S1), .SHIFT_SUM(S2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .weights(wts),
      .thresholds(thr), .inputs(ins), .result(result), .result_valid(result_valid)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int unsigned nxt();
      rng ^= rng << 13;
      rng ^= rng >> 17;
      rng ^= rng << 5;
      return rng;
   endfunction

   task automatic gen(input int mode);
      for (int n = 0; n < P; n++) begin
         for (int k = 0; k < I; k++) begin
            int unsigned r = nxt();
            logic [WW-1:0] w;
            case (mode)
               1:       w = {{14{r[9]}}, r[9:0]};
               2:       w = 24'h7FFFFF;
               3:       w = {1'b1, r[22:0]};
               default: w = r[23:0];
            endcase
            wts[(n*I+k)*WW +: WW] = w;
         end
         begin
            int unsigned r = nxt();
            case (mode)
               3:       thr[n*WW +: WW] = {12'hFFF, r[11:0]};
               4:       thr[n*WW +: WW] = {{6{r[17]}}, r[17:0]};
               default: thr[n*WW +: WW] = r[23:0];
            endcase
         end
      end
      for (int k = 0; k < I; k++) begin
         int unsigned r = nxt();
         case (mode)
            1, 5:    ins[k*IW +: IW] = {{6{r[9]}}, r[9:0]};
            2:       ins[k*IW +: IW] = 16'h7FFF;
            3:       ins[k*IW +: IW] = {1'b0, r[14:0]};
            4:       ins[k*IW +: IW] = '0;
            default: ins[k*IW +: IW] = r[15:0];
         endcase
      end
   endtask

   task automatic predict();
      for (int n = 0; n < P; n++) begin
         longint acc = 0;
         for (int k = 0; k < I; k++) begin
            longint w = longint'($signed(wts[(n*I+k)*WW +: WW]));
            longint x = longint'($signed(ins[k*IW +: IW]));
            acc += (w * x) >>> S1;
         end
         acc += longint'($signed(thr[n*WW +: WW]));
         acc = acc >>> S2;
         if (acc < 0) acc = 0;
         if (acc > MAXV) acc = MAXV;
         expv[n] = acc;
      end
   endtask

   // Called at a negedge while idle; returns at a negedge while idle.
   task automatic run(input int mode, input bit scramble, input bit restart);
      gen(mode);
      predict();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (scramble) gen((mode + 1) % 6);
      for (int j = 1; j <= D + 1; j++) begin
         @(negedge clk);
         if (restart && j == 1) start = 1'b1;
         if (restart && j == 2) start = 1'b0;
         if (j <= D) chk(result_valid == 1'b0, "R5 early strobe", longint'(result_valid), 0);
         else        chk(result_valid == 1'b1, "R5 R10 strobe", longint'(result_valid), 1);
         if (restart && j == D + 1) start = 1'b1;
      end
      for (int n = 0; n < P; n++) begin
         longint act = longint'(result[n*OW +: OW]);
         string tag;
         if (scramble)              tag = "R9 lane";
         else if (expv[n] == 0)     tag = "R3 lane";
         else if (expv[n] == MAXV)  tag = "R4 lane";
         else                       tag = "R2 lane";
         chk(act == expv[n], tag, act, expv[n]);
      end
      held = result;
      @(negedge clk);
      start = 1'b0;
      chk(result_valid == 1'b0, "R6 strobe width", longint'(result_valid), 0);
      chk(result == held, "R8 hold", longint'(result[OW-1:0]), longint'(held[OW-1:0]));
      if (restart) begin
         for (int c = 0; c < D + 3; c++) begin
            @(negedge clk);
            chk(result_valid == 1'b0, "R7 ignored start", longint'(result_valid), 0);
            chk(result == held, "R7 result frozen", longint'(result[OW-1:0]), longint'(held[OW-1:0]));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(result_valid == 1'b0, "R1 valid in reset", longint'(result_valid), 0);
      chk(result == '0, "R1 result in reset", longint'(result[OW-1:0]), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(result_valid == 1'b0, "R1 valid after reset", longint'(result_valid), 0);
      chk(result == '0, "R1 result after reset", longint'(result[OW-1:0]), 0);

      run(2, 1'b0, 1'b0);
      run(3, 1'b0, 1'b0);
      run(4, 1'b0, 1'b0);
      for (int t = 0; t < 240; t++) begin
         run(t % 6, (t % 7) == 3, (t % 11) == 5);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule